// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer load and inspect two small on-chip memories over a three-wire serial link: a serial clock, a data-in line and a data-out line. Every command is a 32-bit frame of four bytes. The block does not clock anything from the serial clock. It samples the serial clock with its own system clock, filters out phases that are too short, and turns each accepted transition into a one-cycle event. Incoming bits are taken on accepted rising transitions, and reply bits move on accepted falling transitions.

The block starts locked. Only an unlock frame is acted on until one has been received, and the block echoes the unlock key back so that the programmer can confirm it is aligned to the frame. Once unlocked, the block can wipe both memories to all ones and write or read bytes of the code memory (16-bit words, low and high halves) and of the data memory. It also answers a poll for its busy state. Every erase or write starts a fixed busy window, and any frame that completes inside that window is discarded.

Code-memory writes can only clear bits. Data-memory writes replace the stored byte outright, because they include their own erase. A pulse on the resync input, held while the serial clock is low, restarts frame alignment and locks the block again.

Top module: `isp_slave`

## Requirements
- R1: Frames are 32 bits, most significant bit first. A command takes effect only after its 32nd accepted rising serial-clock transition. The first byte is the opcode, bytes two and three form a 16-bit address (byte two high), and byte four carries write data.
- R2: Reply bits change only after an accepted falling transition of the serial clock, or after a resync pulse. The reply bit for each position is valid before the rising transition that captures the matching incoming bit.
- R3: A serial-clock high or low phase shorter than MIN_CYC system clocks is ignored. MIN_CYC is 3 when FAST_CLK=0 and 4 when FAST_CLK=1.
- R4: Frame 0xAC 0x80 xx xx sets every byte of the code memory and of the data memory to 0xFF.
- R5: Frame 0xC0 aa aa dd stores dd at data address aa aa and replaces the previous content.
- R6: Frames 0x40 (low byte) and 0x48 (high byte) with address and dd store old AND dd in the addressed code word.
- R7: Each erase or write raises busy for exactly BUSY_CYCLES system clocks.
- R8: A frame that completes while busy is high is discarded. Its write does not occur.
- R9: Until frame 0xAC 0x53 xx xx has been received, every other frame is discarded, and busy never rises. During the third byte of any frame the reply is the second byte received, so the unlock key 0x53 is echoed.
- R10: While the resync input is high, the bit count, the reply register and the unlock state are cleared, and the reply line drives 0.
- R11: In the fourth byte, opcodes 0x20, 0x28 and 0xA0 return the code-low, code-high and data byte at the address when the block is unlocked and idle. Poll frame 0xF0 0x00 xx xx returns busy in bit 0. In every other case the reply is the third byte received. The first reply byte is always 0x00 and the second echoes the opcode.
- R12: Addresses wrap modulo the memory depth: PROG_WORDS for code and DATA_BYTES for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset; memories come up at 0xFF |
| isp_rst | input | 1 | Synchronous resync and relock pulse; hold it at least two clocks with sck low |
| sck | input | 1 | Serial clock from the programmer, asynchronous |
| mosi | input | 1 | Serial command data into the block |
| miso | output | 1 | Serial reply data to the programmer |
| busy | output | 1 | High while a self-timed erase or write runs |

## Verification
The bound checker checks several rules on every clock:
- each accepted serial-clock transition is preceded by a filtered phase of at least MIN_CYC clocks;
- the reply line moves only after a falling event or a resync;
- every busy window lasts exactly BUSY_CYCLES;
- busy never starts while the block is locked;
- a resync leaves the block locked with the reply line low.

Only the bench's scenarios can show what the memory holds and what the block replies:
- erase-to-0xFF;
- the AND-only code writes against the replacing data writes;
- writes dropped under busy;
- address wrap;
- the echo of the unlock key;
- the correct read-out after glitches and after a mid-frame resync.

// File: rtl/isp_pkg.sv
package isp_pkg;
  // Opcodes (first frame byte) and second-byte keys
  localparam logic [7:0] OP_KEY     = 8'hAC;
  localparam logic [7:0] KEY_UNLOCK = 8'h53;
  localparam logic [7:0] KEY_WIPE   = 8'h80;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_WR_LO   = 8'h40;
  localparam logic [7:0] OP_WR_HI   = 8'h48;
  localparam logic [7:0] OP_RD_DAT  = 8'hA0;
  localparam logic [7:0] OP_WR_DAT  = 8'hC0;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  typedef enum logic [1:0] {
    SLOT_LEAD  = 2'd0,
    SLOT_ECHO0 = 2'd1,
    SLOT_ECHO1 = 2'd2,
    SLOT_REPLY = 2'd3
  } slot_e;
endpackage

// File: rtl/isp_edge_filter.sv
// Synchronises sck/mosi and accepts a new sck level only once it has held
// for MIN_CYC consecutive system clocks; emits one-cycle rise/fall events.
module isp_edge_filter #(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  output logic sck_sync,
  output logic rise,
  output logic fall,
  output logic mosi_bit
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [1:0]    sck_ff, mosi_ff;
  logic          lvl;
  logic [CW-1:0] run;

  assign sck_sync = sck_ff[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_ff   <= '0;
      mosi_ff  <= '0;
      lvl      <= 1'b0;
      run      <= '0;
      rise     <= 1'b0;
      fall     <= 1'b0;
      mosi_bit <= 1'b0;
    end else begin
      sck_ff  <= {sck_ff[0], sck};
      mosi_ff <= {mosi_ff[0], mosi};
      rise    <= 1'b0;
      fall    <= 1'b0;
      if (sck_ff[1] == lvl) begin
        run <= '0;
      end else if (run == CW'(MIN_CYC - 1)) begin
        lvl      <= sck_ff[1];
        run      <= '0;
        rise     <= sck_ff[1];
        fall     <= !sck_ff[1];
        mosi_bit <= mosi_ff[1];
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/isp_frame.sv
// 32-bit frame shifter: captures on rise, shifts the reply on fall.
module isp_frame (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        rise,
  input  logic        fall,
  input  logic        mosi_bit,
  input  logic [7:0]  load_byte,
  output logic [31:0] rx,
  output logic [4:0]  bit_cnt,
  output logic        done,
  output logic        miso
);
  logic [7:0] tx;

  assign miso = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx      <= '0;
      bit_cnt <= '0;
      tx      <= '0;
      done    <= 1'b0;
    end else if (clr) begin
      rx      <= '0;
      bit_cnt <= '0;
      tx      <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rise) begin
        rx      <= {rx[30:0], mosi_bit};
        bit_cnt <= bit_cnt + 5'd1;
        done    <= (bit_cnt == 5'd31);
      end
      if (fall) begin
        if (bit_cnt[2:0] == 3'd0) tx <= load_byte;
        else                      tx <= {tx[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/isp_mem.sv
// Code memory (two byte banks, bit-clear-only writes) and data memory
// (replacing writes), both wiped to 0xFF in one cycle.
module isp_mem #(
  parameter int PROG_WORDS = 64,
  parameter int DATA_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        erase,
  input  logic        wr_prog,
  input  logic        wr_hi,
  input  logic        wr_data,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  prog_lo_q,
  output logic [7:0]  prog_hi_q,
  output logic [7:0]  data_q
);
  localparam int PAW = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;
  localparam int DAW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic [PAW-1:0] pa;
  logic [DAW-1:0] da;
  logic [7:0]     prog_q [2];

  assign pa = PAW'(addr % 16'(PROG_WORDS));
  assign da = DAW'(addr % 16'(DATA_BYTES));

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [7:0] cells [PROG_WORDS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < PROG_WORDS; i++) cells[i] <= 8'hFF;
      end else if (erase) begin
        for (int i = 0; i < PROG_WORDS; i++) cells[i] <= 8'hFF;
      end else if (wr_prog && (wr_hi == 1'(g))) begin
        cells[pa] <= cells[pa] & wdata;
      end
    end
    assign prog_q[g] = cells[pa];
  end

  logic [7:0] dcells [DATA_BYTES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_BYTES; i++) dcells[i] <= 8'hFF;
    end else if (erase) begin
      for (int i = 0; i < DATA_BYTES; i++) dcells[i] <= 8'hFF;
    end else if (wr_data) begin
      dcells[da] <= wdata;
    end
  end

  assign prog_lo_q = prog_q[0];
  assign prog_hi_q = prog_q[1];
  assign data_q    = dcells[da];
endmodule

// File: rtl/isp_slave.sv
module isp_slave
  import isp_pkg::*;
#(
  parameter int PROG_WORDS  = 64,
  parameter int DATA_BYTES  = 32,
  parameter int BUSY_CYCLES = 1500,
  parameter bit FAST_CLK    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic isp_rst,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  localparam int MIN_CYC = FAST_CLK ? 4 : 3;
  localparam int BCW     = $clog2(BUSY_CYCLES + 1);

  logic sck_sync, sck_rise, sck_fall, mosi_bit;

  isp_edge_filter #(.MIN_CYC(MIN_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .sck_sync(sck_sync), .rise(sck_rise), .fall(sck_fall), .mosi_bit(mosi_bit)
  );

  logic        frame_done;
  logic [31:0] rx;
  logic [4:0]  bit_cnt;
  logic [7:0]  load_byte;

  isp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .clr(isp_rst), .rise(sck_rise), .fall(sck_fall),
    .mosi_bit(mosi_bit), .load_byte(load_byte), .rx(rx), .bit_cnt(bit_cnt),
    .done(frame_done), .miso(miso)
  );

  // Completed-frame fields
  logic [7:0]  f_op, f_key, f_data;
  logic [15:0] mem_addr;
  assign f_op   = rx[31:24];
  assign f_key  = rx[23:16];
  assign f_data = rx[7:0];
  // On completion the address sits in rx[23:8]; while byte four is being
  // prepared it sits in rx[15:0].
  assign mem_addr = frame_done ? rx[23:8] : rx[15:0];

  logic           prog_en;
  logic [BCW-1:0] busy_cnt;
  logic           accept, do_erase, do_wprog, do_wdata, wr_any;

  assign accept   = frame_done && prog_en && !busy;
  assign do_erase = accept && (f_op == OP_KEY) && (f_key == KEY_WIPE);
  assign do_wprog = accept && ((f_op == OP_WR_LO) || (f_op == OP_WR_HI));
  assign do_wdata = accept && (f_op == OP_WR_DAT);
  assign wr_any   = do_erase || do_wprog || do_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                  prog_en <= 1'b0;
    else if (isp_rst)                                            prog_en <= 1'b0;
    else if (frame_done && f_op == OP_KEY && f_key == KEY_UNLOCK) prog_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (wr_any)           busy_cnt <= BCW'(BUSY_CYCLES);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy = (busy_cnt != '0);

  logic [7:0] prog_lo_q, prog_hi_q, data_q;

  isp_mem #(.PROG_WORDS(PROG_WORDS), .DATA_BYTES(DATA_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .erase(do_erase), .wr_prog(do_wprog),
    .wr_hi(f_op == OP_WR_HI), .wr_data(do_wdata), .addr(mem_addr),
    .wdata(f_data), .prog_lo_q(prog_lo_q), .prog_hi_q(prog_hi_q), .data_q(data_q)
  );

  // Fourth-byte reply
  logic [7:0] reply3;
  always_comb begin
    reply3 = rx[7:0];
    if (prog_en) begin
      if (rx[23:16] == OP_POLL && rx[15:8] == 8'h00) begin
        reply3 = {7'b0, busy};
      end else if (!busy) begin
        case (rx[23:16])
          OP_RD_LO:  reply3 = prog_lo_q;
          OP_RD_HI:  reply3 = prog_hi_q;
          OP_RD_DAT: reply3 = data_q;
          default:   reply3 = rx[7:0];
        endcase
      end
    end
  end

  always_comb begin
    case (slot_e'(bit_cnt[4:3]))
      SLOT_LEAD:  load_byte = 8'h00;
      SLOT_REPLY: load_byte = reply3;
      default:    load_byte = rx[7:0];
    endcase
  end
endmodule

// File: rtl/isp_slave_chk.sv
module isp_slave_chk #(
  parameter int MIN_CYC     = 3,
  parameter int BUSY_CYCLES = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic isp_rst,
  input logic miso,
  input logic busy,
  input logic sck_sync,
  input logic rise,
  input logic fall,
  input logic prog_en
);
  logic [3:0] hi_run, lo_run;
  int         blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      blen   <= 0;
    end else begin
      hi_run <= sck_sync  ? ((hi_run == 4'hF) ? hi_run : hi_run + 4'd1) : 4'd0;
      lo_run <= !sck_sync ? ((lo_run == 4'hF) ? lo_run : lo_run + 4'd1) : 4'd0;
      blen   <= busy ? blen + 1 : 0;
    end
  end

  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(fall) || $past(isp_rst)));

  p_rise_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (hi_run >= 4'(MIN_CYC)));

  p_fall_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (lo_run >= 4'(MIN_CYC)));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == BUSY_CYCLES));

  p_busy_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_en));

  p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    isp_rst |=> (!prog_en && !miso));
endmodule

bind isp_slave isp_slave_chk #(.MIN_CYC(MIN_CYC), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .isp_rst(isp_rst), .miso(miso), .busy(busy),
  .sck_sync(sck_sync), .rise(sck_rise), .fall(sck_fall), .prog_en(prog_en)
);

// File: tb/test_isp_slave.sv
`timescale 1ns/1ps
module test_isp_slave;
  localparam int PW   = 64;
  localparam int DB   = 32;
  localparam int BUSY = 1500;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0, isp_rst = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy;

  always #5 clk = ~clk;

  isp_slave #(.PROG_WORDS(PW), .DATA_BYTES(DB), .BUSY_CYCLES(BUSY), .FAST_CLK(1'b0)) i_isp_slave (
    .clk(clk), .rst_n(rst_n), .isp_rst(isp_rst), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // Behavioural reference model
  logic [7:0] m_lo [PW];
  logic [7:0] m_hi [PW];
  logic [7:0] m_dat [DB];
  bit m_en = 0, m_busy = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_resp(input logic [31:0] c);
    logic [7:0] op, r3;
    int pa, da;
    op = c[31:24];
    pa = int'(c[23:8]) % PW;
    da = int'(c[23:8]) % DB;
    r3 = c[15:8];
    if (m_en && op == 8'hF0 && c[23:16] == 8'h00) r3 = {7'b0, m_busy};
    else if (m_en && !m_busy) begin
      if (op == 8'h20) r3 = m_lo[pa];
      else if (op == 8'h28) r3 = m_hi[pa];
      else if (op == 8'hA0) r3 = m_dat[da];
    end
    return {8'h00, c[31:24], c[23:16], r3};
  endfunction

  task automatic apply_model(input logic [31:0] c);
    logic [7:0] op;
    int pa, da;
    op = c[31:24];
    pa = int'(c[23:8]) % PW;
    da = int'(c[23:8]) % DB;
    if (!m_en) begin
      if (op == 8'hAC && c[23:16] == 8'h53) m_en = 1;
    end else if (!m_busy) begin
      if (op == 8'hAC && c[23:16] == 8'h80) begin
        for (int i = 0; i < PW; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
        for (int i = 0; i < DB; i++) m_dat[i] = 8'hFF;
        m_busy = 1;
      end else if (op == 8'h40) begin m_lo[pa] = m_lo[pa] & c[7:0]; m_busy = 1; end
      else if (op == 8'h48) begin m_hi[pa] = m_hi[pa] & c[7:0]; m_busy = 1; end
      else if (op == 8'hC0) begin m_dat[da] = c[7:0]; m_busy = 1; end
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shifts nbits of cmd MSB first; reply sampled just before each rise.
  task automatic xfer(input logic [31:0] cmd, input int nbits, input bit glitch, output logic [31:0] resp);
    resp = '0;
    for (int k = 0; k < nbits; k++) begin
      mosi = cmd[31-k];
      if (glitch) begin
        wait_n(3); sck = 1'b1; wait_n(2); sck = 1'b0; wait_n(HALF - 5);
      end else wait_n(HALF);
      resp[31-k] = miso;
      sck = 1'b1;
      if (glitch) begin
        wait_n(3); sck = 1'b0; wait_n(2); sck = 1'b1; wait_n(HALF - 5);
      end else wait_n(HALF);
      sck = 1'b0;
    end
    wait_n(HALF);
  endtask

  task automatic do_cmd(input logic [31:0] cmd, input bit glitch, input string req, output logic [31:0] resp);
    logic [31:0] e;
    e = exp_resp(cmd);
    xfer(cmd, 32, glitch, resp);
    check(resp === e, req, resp, e);
    apply_model(cmd);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 4 * BUSY) begin @(negedge clk); n++; end
    check(busy === 1'b0, "R7 busy ends", {31'b0, busy}, 32'h0);
    m_busy = 0;
  endtask

  logic [31:0] r;

  initial begin
    for (int i = 0; i < PW; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
    for (int i = 0; i < DB; i++) m_dat[i] = 8'hFF;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    check(miso === 1'b0, "R10 reset miso", {31'b0, miso}, 32'h0);
    check(busy === 1'b0, "R7 reset busy", {31'b0, busy}, 32'h0);

    // R9: locked block ignores writes and reads
    do_cmd(32'h2000_0300, 0, "R9 locked read echoes", r);
    do_cmd(32'hC000_05AA, 0, "R9 locked write", r);
    check(busy === 1'b0, "R9 no busy while locked", {31'b0, busy}, 32'h0);

    // R9/R3: unlock with glitched sck, key echoed in byte three
    do_cmd(32'hAC53_1234, 1, "R3 R1 unlock with glitches", r);
    check(r[15:8] === 8'h53, "R9 key echo", {24'b0, r[15:8]}, 32'h53);
    do_cmd(32'hA000_0500, 0, "R9 R11 data read after lock write", r);

    // R5 / R8 / R11 / R7
    do_cmd(32'hC000_053C, 0, "R5 data write", r);
    check(busy === 1'b1, "R7 busy after write", {31'b0, busy}, 32'h1);
    do_cmd(32'hF000_0000, 0, "R11 poll busy", r);
    do_cmd(32'hC000_0511, 0, "R8 dropped write", r);
    wait_idle();
    do_cmd(32'hA000_0500, 1, "R8 R11 read back", r);
    do_cmd(32'hC000_05C3, 0, "R5 replace write", r);
    wait_idle();
    do_cmd(32'hA000_0500, 0, "R5 replaced value", r);

    // R6 code writes only clear bits
    do_cmd(32'h4000_03F0, 0, "R6 code lo write", r);
    wait_idle();
    do_cmd(32'h4000_033C, 0, "R6 code lo second write", r);
    wait_idle();
    do_cmd(32'h4800_035A, 0, "R6 code hi write", r);
    wait_idle();
    do_cmd(32'h2000_0300, 0, "R6 code lo AND", r);
    do_cmd(32'h2800_0300, 0, "R6 code hi", r);
    check(r[7:0] === 8'h5A, "R6 hi value", {24'b0, r[7:0]}, 32'h5A);

    // R12 address wrap
    do_cmd(32'h2001_4300, 0, "R12 code wrap", r);
    do_cmd(32'hA000_2500, 0, "R12 data wrap", r);
    check(r[7:0] === 8'hC3, "R12 data wrap value", {24'b0, r[7:0]}, 32'hC3);

    // R4 wipe
    do_cmd(32'hAC80_0000, 0, "R4 wipe", r);
    wait_idle();
    do_cmd(32'hF000_0000, 0, "R11 poll idle", r);
    do_cmd(32'hA000_0500, 0, "R4 data wiped", r);
    do_cmd(32'h2000_0300, 0, "R4 code lo wiped", r);
    do_cmd(32'h2800_0300, 0, "R4 code hi wiped", r);
    check(r[7:0] === 8'hFF, "R4 value", {24'b0, r[7:0]}, 32'hFF);

    // R10 resync mid-frame, then relock
    do_cmd(32'hC000_0777, 0, "R10 setup write", r);
    wait_idle();
    xfer(32'hA000_0700, 16, 0, r);
    isp_rst = 1'b1; wait_n(3); isp_rst = 1'b0; wait_n(2);
    check(miso === 1'b0, "R10 miso after resync", {31'b0, miso}, 32'h0);
    m_en = 0;
    do_cmd(32'hA000_0700, 0, "R10 relocked read echoes", r);
    do_cmd(32'hAC53_0000, 0, "R10 unlock again", r);
    do_cmd(32'hA000_0700, 0, "R10 aligned read", r);
    check(r[7:0] === 8'h77, "R10 value", {24'b0, r[7:0]}, 32'h77);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule